// File: doc/BRIEF.md
# Buck Phase Gate Sequencer

This block sequences the high-side and low-side switch enables of one synchronous buck phase. It takes two already-digitized three-level commands: one picks the conducting switch or the diode-emulation mode, the other runs or parks the phase. Both commands cross into the clock domain through a two-flop synchronizer. After that they are decoded into levels that drive a small state machine.

Dead time is adaptive. Each switch turns on only after a comparator flag reports that the opposite gate has discharged. In diode-emulation mode the low-side switch conducts for a blanking interval given in picoseconds and rounded up to whole clocks. After that interval the low-side switch turns off on the first zero-cross flag. A supply-good input parks both switches whenever the supply is below its threshold. Every way back into switching passes through a state with both switches off.

Top module: `buck_gate_seq`

## Requirements
- R1: During and directly after reset, both `hi_en_o` and `lo_en_o` are 0.
- R2: Both command codes use the same encoding: 2'b00 is low, 2'b11 is high and 2'b01 is mid. With the run command high, a switch-code of 2'b00 ends in `lo_en_o`=1 and 2'b11 ends in `hi_en_o`=1. A command change at the pins reaches the state on the third rising edge.
- R3: The unused code 2'b10 is treated as mid, on either command.
- R4: When the switch-code goes high, `lo_en_o` drops first. `hi_en_o` rises only on the edge after `lo_off_i`=1 is sampled, so there is at least one cycle with both outputs off.
- R5: When the switch-code goes low, `hi_en_o` drops first. `lo_en_o` rises only on the edge after `hi_off_i`=1 is sampled.
- R6: On a mid switch-code, `hi_en_o` drops. After `hi_off_i`=1, `lo_en_o` rises and stays high for exactly ceil(BLANK_PS/CLK_PERIOD_PS) cycles, and `zero_cross_i` is ignored during that time.
- R7: After blanking, `lo_en_o` stays high until `zero_cross_i`=1 is sampled. It then drops on that edge, and both outputs stay off for as long as the switch-code remains mid.
- R8: A high or low switch-code clears the diode-emulation progress, so a later mid command runs the full sequence again.
- R9: A run-code of 2'b00, 2'b01 or 2'b10 forces both outputs off, three edges after the change at the pins.
- R10: `supply_ok_i`=0 forces both outputs off on the next edge.
- R11: After a forced-off period, switching resumes only through the adaptive wait: `hi_en_o` stays off until `lo_off_i`=1 is seen.
- R12: `hi_en_o` and `lo_en_o` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sw_code_i | input | 2 | Three-level switch command (low / mid / high) |
| run_code_i | input | 2 | Three-level run command (off / park / run) |
| supply_ok_i | input | 1 | Supply above the lockout threshold |
| lo_off_i | input | 1 | Low-side gate discharged below threshold |
| hi_off_i | input | 1 | High-side gate discharged below threshold |
| zero_cross_i | input | 1 | Inductor current zero-cross flag |
| hi_en_o | output | 1 | High-side switch enable |
| lo_en_o | output | 1 | Low-side switch enable |

## Verification
The outputs are a pure decode of the state, so a wrong state shows at the ports in the same cycle it is entered. A skipped wait state appears as an enable rising while a discharge flag is held low. A miscounted blanking timer changes the number of cycles `lo_en_o` is high by at least one. The bench holds the flags low for many cycles, counts the low-side pulse width cycle by cycle, and checks the exact three-edge command latency. Any of these faults is therefore exposed within a few cycles of the stimulus that reaches it.

// File: rtl/buck_gate_pkg.sv
package buck_gate_pkg;

  typedef enum logic [1:0] {LVL_LOW, LVL_MID, LVL_HIGH} lvl_e;

  typedef enum logic [3:0] {
    ST_OFF,
    ST_HS_WAIT,
    ST_HS_ON,
    ST_LS_WAIT,
    ST_LS_ON,
    ST_DE_WAIT,
    ST_DE_BLANK,
    ST_DE_WATCH,
    ST_DE_DONE
  } state_e;

  localparam logic [1:0] CODE_LOW  = 2'b00;
  localparam logic [1:0] CODE_HIGH = 2'b11;

  // unused code 2'b10 folds into mid
  function automatic lvl_e decode_lvl(input logic [1:0] code);
    case (code)
      CODE_LOW:  decode_lvl = LVL_LOW;
      CODE_HIGH: decode_lvl = LVL_HIGH;
      default:   decode_lvl = LVL_MID;
    endcase
  endfunction

endpackage

// File: rtl/buck_gate_sync.sv
module buck_gate_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q[0] <= '0;
    else         stage_q[0] <= d_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[g] <= '0;
      else         stage_q[g] <= stage_q[g-1];
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/buck_gate_decode.sv
module buck_gate_decode
  import buck_gate_pkg::*;
#(
  parameter int unsigned NUM_CMD = 2
) (
  input  logic [2*NUM_CMD-1:0] code_i,
  output lvl_e                 lvl_o [NUM_CMD]
);

  for (genvar g = 0; g < NUM_CMD; g++) begin : g_dec
    assign lvl_o[g] = decode_lvl(code_i[2*g +: 2]);
  end

endmodule

// File: rtl/buck_gate_blank.sv
module buck_gate_blank #(
  parameter int unsigned CYCLES = 35,
  localparam int unsigned CNT_W = (CYCLES < 2) ? 1 : $clog2(CYCLES)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic run_i,
  output logic done_o
);

  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (load_i)                 cnt_q <= LOAD_VAL;
    else if (run_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

endmodule

// File: rtl/buck_gate_fsm.sv
module buck_gate_fsm
  import buck_gate_pkg::*;
#(
  parameter int unsigned BLANK_CYC = 35
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  lvl_e sw_lvl_i,
  input  lvl_e run_lvl_i,
  input  logic supply_ok_i,
  input  logic lo_off_i,
  input  logic hi_off_i,
  input  logic zero_cross_i,
  output logic hi_en_o,
  output logic lo_en_o
);

  state_e state_q, state_d;
  logic   run, blank_load, blank_done;

  assign run = supply_ok_i && (run_lvl_i == LVL_HIGH);

  always_comb begin
    state_d    = state_q;
    blank_load = 1'b0;
    if (!run) begin
      state_d = ST_OFF;
    end else begin
      case (sw_lvl_i)
        LVL_HIGH: begin
          case (state_q)
            ST_HS_ON:   ;
            ST_HS_WAIT: if (lo_off_i) state_d = ST_HS_ON;
            default:    state_d = ST_HS_WAIT;
          endcase
        end
        LVL_LOW: begin
          case (state_q)
            ST_LS_ON:   ;
            ST_LS_WAIT: if (hi_off_i) state_d = ST_LS_ON;
            default:    state_d = ST_LS_WAIT;
          endcase
        end
        default: begin
          case (state_q)
            ST_DE_WAIT: if (hi_off_i) begin
              state_d    = ST_DE_BLANK;
              blank_load = 1'b1;
            end
            ST_DE_BLANK: if (blank_done) state_d = ST_DE_WATCH;
            ST_DE_WATCH: if (zero_cross_i) state_d = ST_DE_DONE;
            ST_DE_DONE:  ;
            default:     state_d = ST_DE_WAIT;
          endcase
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_OFF;
    else         state_q <= state_d;
  end

  buck_gate_blank #(.CYCLES(BLANK_CYC)) u_blank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (blank_load),
    .run_i  (state_q == ST_DE_BLANK),
    .done_o (blank_done)
  );

  assign hi_en_o = (state_q == ST_HS_ON);
  assign lo_en_o = (state_q == ST_LS_ON) || (state_q == ST_DE_BLANK) ||
                   (state_q == ST_DE_WATCH);

  assert_no_overlap_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hi_en_o && lo_en_o));

  assert_hi_waits_flag_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hi_en_o) |-> $past(lo_off_i));

  assert_lo_waits_flag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lo_en_o) |-> $past(hi_off_i));

  assert_blank_holds_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DE_BLANK && run && sw_lvl_i == LVL_MID) |=> lo_en_o);

  assert_zc_turnoff_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DE_WATCH && zero_cross_i) |=> !lo_en_o);

  assert_uvlo_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_i |=> (!hi_en_o && !lo_en_o));

endmodule

// File: rtl/buck_gate_seq.sv
module buck_gate_seq
  import buck_gate_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS = 10000,
  parameter int unsigned BLANK_PS      = 350000,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] sw_code_i,
  input  logic [1:0] run_code_i,
  input  logic       supply_ok_i,
  input  logic       lo_off_i,
  input  logic       hi_off_i,
  input  logic       zero_cross_i,
  output logic       hi_en_o,
  output logic       lo_en_o
);

  localparam int unsigned BLANK_RAW = (BLANK_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  localparam int unsigned BLANK_CYC = (BLANK_RAW < 1) ? 1 : BLANK_RAW;

  logic [3:0] cmd_sync;
  lvl_e       lvl [2];

  buck_gate_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({run_code_i, sw_code_i}),
    .q_o    (cmd_sync)
  );

  buck_gate_decode #(.NUM_CMD(2)) u_dec (
    .code_i (cmd_sync),
    .lvl_o  (lvl)
  );

  buck_gate_fsm #(.BLANK_CYC(BLANK_CYC)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sw_lvl_i     (lvl[0]),
    .run_lvl_i    (lvl[1]),
    .supply_ok_i  (supply_ok_i),
    .lo_off_i     (lo_off_i),
    .hi_off_i     (hi_off_i),
    .zero_cross_i (zero_cross_i),
    .hi_en_o      (hi_en_o),
    .lo_en_o      (lo_en_o)
  );

endmodule

// File: tb/buck_gate_seq_tb.sv
`timescale 1ns/1ps
module buck_gate_seq_tb;

  localparam int CLK_NS   = 10;
  localparam int CLK_PS   = 10000;
  localparam int BLANK_PS = 42000;
  localparam int BLANK    = (BLANK_PS + CLK_PS - 1) / CLK_PS;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] sw_code = 2'b00, run_code = 2'b00;
  logic       supply_ok = 1'b0, lo_off = 1'b1, hi_off = 1'b1, zc = 1'b0;
  logic       hi_en, lo_en;
  int         n_run = 0, n_fail = 0, n_overlap = 0;

  always #(CLK_NS/2) clk = ~clk;

  buck_gate_seq #(.CLK_PERIOD_PS(CLK_PS), .BLANK_PS(BLANK_PS)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .sw_code_i(sw_code), .run_code_i(run_code),
    .supply_ok_i(supply_ok), .lo_off_i(lo_off), .hi_off_i(hi_off),
    .zero_cross_i(zc), .hi_en_o(hi_en), .lo_en_o(lo_en)
  );

  always @(negedge clk) if (hi_en && lo_en) n_overlap++;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [1:0] exp);
    n_run++;
    if ({hi_en, lo_en} !== exp) begin
      n_fail++;
      $display("FAIL %s: {hi,lo}=%b expected %b at %0t", req, {hi_en, lo_en}, exp, $time);
    end
  endtask

  initial begin
    #(CLK_NS * 50000);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    tick(2);
    chk("R1 in reset", 2'b00);
    rst_ni = 1'b1;
    tick(1);
    chk("R1 after reset", 2'b00);

    // R2: low command, three-edge latency
    supply_ok = 1'b1; run_code = 2'b11; sw_code = 2'b00;
    tick(3); chk("R5 wait state", 2'b00);
    tick(1); chk("R2 low selects lo", 2'b01);

    // R4: high-side waits for low-side discharge
    lo_off = 1'b0; sw_code = 2'b11;
    tick(2); chk("R2 latency not yet", 2'b01);
    tick(1); chk("R4 lo dropped", 2'b00);
    tick(10); chk("R4 hi held off", 2'b00);
    lo_off = 1'b1;
    tick(1); chk("R4 hi after flag", 2'b10);

    // R5: low-side waits for high-side discharge
    hi_off = 1'b0; sw_code = 2'b00;
    tick(3); chk("R5 hi dropped", 2'b00);
    tick(10); chk("R5 lo held off", 2'b00);
    hi_off = 1'b1;
    tick(1); chk("R5 lo after flag", 2'b01);

    // R6: blanking width with zero-cross already high
    zc = 1'b1; sw_code = 2'b01;
    tick(3); chk("R6 dead time", 2'b00);
    for (int i = 0; i < BLANK + 1; i++) begin
      tick(1); chk("R6 lo through blank+watch", 2'b01);
    end
    tick(1); chk("R7 zc turn-off", 2'b00);
    zc = 1'b0;
    tick(5); chk("R7 stays off", 2'b00);

    // R3 + R7: illegal code as mid, lo held until zero-cross
    sw_code = 2'b00; tick(6);
    sw_code = 2'b10; tick(4);
    chk("R3 illegal code enters blank", 2'b01);
    tick(BLANK + 20); chk("R7 lo held without zc", 2'b01);
    zc = 1'b1; tick(1); chk("R7 off on zc", 2'b00);
    zc = 1'b0; tick(3); chk("R7 done holds", 2'b00);

    // R8: fresh mid after high restarts
    sw_code = 2'b11; tick(6); chk("R8 high", 2'b10);
    zc = 1'b1; sw_code = 2'b01; tick(4);
    chk("R8 sequence restarted", 2'b01);

    // R2/R3 sweep of switch codes, zc high to separate mid from low
    for (int c = 0; c < 4; c++) begin
      zc = 1'b0; sw_code = 2'b00; tick(6);
      zc = 1'b1; sw_code = 2'(c); tick(BLANK + 10);
      if (c == 0)      chk("R2 sweep code 00", 2'b01);
      else if (c == 3) chk("R2 sweep code 11", 2'b10);
      else             chk("R3 sweep mid code", 2'b00);
    end
    zc = 1'b0;

    // R9 sweep of run codes, exact latency
    sw_code = 2'b11;
    for (int c = 0; c < 4; c++) begin
      run_code = 2'b11; tick(8);
      run_code = 2'(c);
      tick(2); chk("R9 before latency", 2'b10);
      tick(1);
      if (c == 3) chk("R9 run code 11", 2'b10);
      else        chk("R9 park code", 2'b00);
    end
    run_code = 2'b11; tick(8);

    // R10 / R11
    supply_ok = 1'b0;
    tick(1); chk("R10 uvlo next edge", 2'b00);
    tick(5); chk("R10 uvlo holds", 2'b00);
    lo_off = 1'b0; supply_ok = 1'b1;
    tick(5); chk("R11 resumes via wait", 2'b00);
    lo_off = 1'b1;
    tick(1); chk("R11 hi after flag", 2'b10);

    n_run++;
    if (n_overlap != 0) begin
      n_fail++;
      $display("FAIL R12: overlap cycles=%0d expected 0", n_overlap);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule